// File: doc/BRIEF.md
# Byte-Banked Unaligned Word Memory

This block is a byte-addressable store with a 32-bit port that completes any access of one, two or four bytes in a single accepted cycle, whatever the starting byte address. The storage is split into four byte-wide banks. Lane k of the banks holds every byte whose address modulo four equals k, and the row of a byte is its address shifted right by two. A word that straddles two rows is served in one cycle because each lane picks its own row. Lanes numbered below the starting offset take the following row, and the other lanes take the base row.

Requests enter through a valid/ready handshake carrying address, size, write flag and write data. Write data is rotated so that its least significant byte lands at the start address. Only the lanes the access covers are written. Reads are synchronous. The banks register their bytes on the accepting edge, and a rotator after the registers steers the start byte to the least significant position of the response.

A read response is offered on a valid/ready output. While a response is shown and the consumer holds ready low, the response stays stable and the request side drops its ready, so no further request is taken until the response is consumed. Writes never produce a response.

Top module: `ubank_mem`

## Requirements
- R1: After reset, rsp_valid is low and req_ready is high.
- R2: A 4-byte write at a word-aligned address followed by a 4-byte read of the same address returns the written word unchanged.
- R3: A 4-byte read at a byte address A with A mod 4 not zero returns byte A in bits 7:0, A+1 in 15:8, A+2 in 23:16 and A+3 in 31:24, including when the bytes span two rows.
- R4: A 4-byte write at an unaligned address A stores req_wdata bits 7:0 at A, 15:8 at A+1, 23:16 at A+2 and 31:24 at A+3.
- R5: Size encoding 0 writes one byte and encoding 1 writes two bytes (req_wdata 7:0 at A, 15:8 at A+1), starting at any offset. Every other byte of memory keeps its contents.
- R6: A read with size encoding 0 returns the byte in bits 7:0 and zeros above. A read with encoding 1 returns two bytes in bits 15:0 and zeros above. Encodings 2 and 3 both mean four bytes.
- R7: Addresses wrap modulo the memory size. An access that runs past the last byte continues at byte 0.
- R8: While rsp_valid is high and rsp_ready is low, req_ready is low, and rsp_valid and rsp_rdata keep their values.
- R9: An accepted write causes no response: rsp_valid is low in the cycle after it.
- R10: The response to a read accepted on a clock edge is presented with rsp_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 8 | Byte address (log2(ROWS)+2 bits) |
| req_size | input | 2 | 0 = one byte, 1 = two bytes, 2 or 3 = four bytes |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, first byte in bits 7:0 |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, first byte in bits 7:0, unused bytes zero |

## Verification
Every read's result is due in the cycle that starts at the edge that accepted it, and it stays until an edge on which rsp_ready is high. Writes take effect at the accepting edge and are visible to a read accepted on any later edge. The driver places requests at falling edges and records the expected data when a read is accepted. The monitor compares at falling edges, only when a response is both valid and ready. A stall is checked by holding rsp_ready low for several falling-edge samples, and the one-cycle latency and the absence of write responses are sampled just after the accepting edge.

// File: rtl/ubm_pkg.sv
package ubm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // number of bytes an access of the given size spans
  function automatic logic [7:0] span_of(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: span_of = 8'd1;
      SZ_HALF: span_of = 8'd2;
      default: span_of = 8'd4;
    endcase
  endfunction

endpackage

// File: rtl/ubm_lane_ctl.sv
module ubm_lane_ctl #(
  parameter int LANES = 4,
  parameter int RW    = 6,
  localparam int OW   = $clog2(LANES)
) (
  input  logic                     fire,
  input  logic                     is_write,
  input  logic [RW-1:0]            base_row,
  input  logic [OW-1:0]            offset,
  input  logic [1:0]               size,
  output logic [LANES-1:0][RW-1:0] lane_row,
  output logic [LANES-1:0]         lane_en,
  output logic [LANES-1:0]         lane_we
);
  import ubm_pkg::*;

  logic [7:0] span;
  assign span = span_of(size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic          bump;
    logic [OW-1:0] rel;
    logic          covered;

    // lanes below the start offset hold the bytes of the following row
    assign bump        = OW'(k) < offset;
    assign lane_row[k] = bump ? base_row + RW'(1) : base_row;

    // position of this lane inside the access, counted from the start byte
    assign rel     = OW'(k) - offset;
    assign covered = 8'(rel) < span;

    assign lane_en[k] = fire && (!is_write || covered);
    assign lane_we[k] = is_write;
  end

endmodule

// File: rtl/ubm_bank.sv
module ubm_bank #(
  parameter int ROWS = 64,
  parameter int BW   = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [BW-1:0] wbyte,
  output logic [BW-1:0] rbyte
);
  logic [BW-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[row] <= wbyte;
      else    rbyte      <= cells[row];
    end
  end

endmodule

// File: rtl/ubm_rotate.sv
module ubm_rotate #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter bit RIGHT = 1'b1,
  localparam int OW   = $clog2(LANES)
) (
  input  logic [LANES*BW-1:0] din,
  input  logic [OW-1:0]       amt,
  output logic [LANES*BW-1:0] dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [OW-1:0] src;
    if (RIGHT) begin : g_r
      assign src = OW'(j) + amt;
    end else begin : g_l
      assign src = OW'(j) - amt;
    end
    assign dout[j*BW +: BW] = din[src*BW +: BW];
  end

endmodule

// File: rtl/ubank_mem.sv
module ubank_mem #(
  parameter int ROWS  = 64,
  parameter int LANES = 4,
  localparam int BW   = 8,
  localparam int DW   = LANES * BW,
  localparam int OW   = $clog2(LANES),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = RW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  import ubm_pkg::*;

  logic                     fire, rd_fire;
  logic [RW-1:0]            base_row;
  logic [OW-1:0]            offset;
  logic [LANES-1:0][RW-1:0] lane_row;
  logic [LANES-1:0]         lane_en, lane_we;
  logic [DW-1:0]            wr_lanes, rd_lanes, rd_rot;
  logic [OW-1:0]            off_q;
  logic [1:0]               size_q;
  logic [7:0]               span_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_we;
  assign base_row  = req_addr[AW-1:OW];
  assign offset    = req_addr[OW-1:0];

  ubm_lane_ctl #(.LANES(LANES), .RW(RW)) u_ctl (
    .fire     (fire),
    .is_write (req_we),
    .base_row (base_row),
    .offset   (offset),
    .size     (req_size),
    .lane_row (lane_row),
    .lane_en  (lane_en),
    .lane_we  (lane_we)
  );

  // write path: first byte moves to the lane of the start address
  ubm_rotate #(.LANES(LANES), .BW(BW), .RIGHT(1'b0)) u_wrot (
    .din  (req_wdata),
    .amt  (offset),
    .dout (wr_lanes)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    ubm_bank #(.ROWS(ROWS), .BW(BW)) u_bank (
      .clk   (clk),
      .en    (lane_en[k]),
      .we    (lane_we[k]),
      .row   (lane_row[k]),
      .wbyte (wr_lanes[k*BW +: BW]),
      .rbyte (rd_lanes[k*BW +: BW])
    );
  end

  // response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      off_q     <= '0;
      size_q    <= '0;
    end else begin
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        off_q     <= offset;
        size_q    <= req_size;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // read path: start byte moves to the least significant position
  ubm_rotate #(.LANES(LANES), .BW(BW), .RIGHT(1'b1)) u_rrot (
    .din  (rd_lanes),
    .amt  (off_q),
    .dout (rd_rot)
  );

  assign span_q = span_of(size_q);

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign rsp_rdata[j*BW +: BW] = (8'(j) < span_q) ? rd_rot[j*BW +: BW] : '0;
  end

endmodule

// File: rtl/ubm_check.sv
module ubm_check #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_we,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata
);
  logic [1:0] seen_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_size <= 2'd0;
    else if (req_valid && req_ready && !req_we) seen_size <= req_size;
  end

  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid);

  a_r9_no_wr_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> !rsp_valid);

  a_r6_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_size == 2'd0) |-> (rsp_rdata[DW-1:8] == '0));

  a_r6_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_size == 2'd1) |-> (rsp_rdata[DW-1:16] == '0));

endmodule

bind ubank_mem ubm_check u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata)
);

// File: tb/ubank_mem_test.sv
`timescale 1ns/1ps
module ubank_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic [7:0]  model [256];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  ubank_mem uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // driver: places one request and returns just after the accepting edge
  task automatic issue(input logic we, input logic [7:0] a, input logic [1:0] s,
                       input logic [31:0] d, input string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_size = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    e = '0;
    for (int i = 0; i < nbytes(s); i++) begin
      if (we) model[8'(a + 8'(i))] = d[i*8 +: 8];
      else    e[i*8 +: 8] = model[8'(a + 8'(i))];
    end
    if (!we) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor: compares every consumed response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'h1);

    // fill every row with aligned word writes
    for (int w = 0; w < 64; w++)
      issue(1'b1, 8'(w*4), 2'd2, 32'hA5C3_0F00 ^ (32'(w) * 32'h0103_0507), "R2");
    check(rsp_valid === 1'b0, "R9 no response after write", 32'(rsp_valid), 32'h0);

    // R2 aligned reads
    for (int w = 0; w < 64; w += 9) issue(1'b0, 8'(w*4), 2'd2, '0, "R2 aligned read");

    // R10 latency
    issue(1'b0, 8'h40, 2'd3, '0, "R10 data");
    check(rsp_valid === 1'b1, "R10 valid after accept", 32'(rsp_valid), 32'h1);

    // R3 unaligned word reads
    issue(1'b0, 8'h11, 2'd2, '0, "R3 off1");
    issue(1'b0, 8'h22, 2'd2, '0, "R3 off2");
    issue(1'b0, 8'h33, 2'd2, '0, "R3 off3");
    issue(1'b0, 8'h47, 2'd2, '0, "R3 off3b");

    // R4 unaligned word writes, read back aligned
    issue(1'b1, 8'h29, 2'd2, 32'h1122_3344, "R4");
    issue(1'b1, 8'h36, 2'd2, 32'hDEAD_BEEF, "R4");
    issue(1'b0, 8'h28, 2'd2, '0, "R4 row28");
    issue(1'b0, 8'h2C, 2'd2, '0, "R4 row2C");
    issue(1'b0, 8'h34, 2'd2, '0, "R4 row34");
    issue(1'b0, 8'h38, 2'd2, '0, "R4 row38");

    // R5 partial writes keep neighbours
    issue(1'b1, 8'h51, 2'd0, 32'hFFFF_FF7E, "R5");
    issue(1'b1, 8'h5A, 2'd1, 32'hFFFF_C0DE, "R5");
    issue(1'b1, 8'h63, 2'd1, 32'hFFFF_9A8B, "R5");
    issue(1'b0, 8'h50, 2'd2, '0, "R5 row50");
    issue(1'b0, 8'h58, 2'd2, '0, "R5 row58");
    issue(1'b0, 8'h60, 2'd2, '0, "R5 row60");
    issue(1'b0, 8'h64, 2'd2, '0, "R5 row64");

    // R6 partial reads zero the upper bytes
    issue(1'b0, 8'h47, 2'd0, '0, "R6 byte");
    issue(1'b0, 8'h13, 2'd1, '0, "R6 half crossing");
    issue(1'b0, 8'h1E, 2'd1, '0, "R6 half");

    // R7 wrap past the top byte
    issue(1'b1, 8'hFE, 2'd2, 32'h0BAD_F00D, "R7");
    issue(1'b0, 8'hFC, 2'd2, '0, "R7 top row");
    issue(1'b0, 8'h00, 2'd2, '0, "R7 row0");
    issue(1'b0, 8'hFD, 2'd2, '0, "R7 wrap read");

    // R8 back-pressure
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    issue(1'b0, 8'h24, 2'd2, '0, "R8 data");
    held = rsp_rdata;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1, "R8 valid held", 32'(rsp_valid), 32'h1);
      check(req_ready === 1'b0, "R8 ready low", 32'(req_ready), 32'h0);
      check(rsp_rdata === held, "R8 data stable", rsp_rdata, held);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule